// File: doc/BRIEF.md
# Four-Bit Shift and Rotate Unit

This block moves the bits of a four-bit word by zero to three positions in one step. It can shift or rotate, to the left or to the right. A shift can be logical, which fills the vacated positions with zeros, or arithmetic, which keeps the sign. Three mode bits and a two-bit amount together form a five-bit control code. Each output bit is taken from a 32-entry column of candidate values indexed by that code. The column is reduced by a tree of two-input multiplexers. The first level of the tree is steered by the most significant control bit, and the last level by the least significant amount bit.

With the default configuration, the result and a valid flag are held in an output register. They appear one clock after the inputs are presented. Setting `OUT_REG` to 0 removes the register and the result follows the inputs combinationally. A datapath places the unit wherever a narrow variable shift or rotate is needed in a single step.

Top module: `nibble_shifter`

## Requirements
- R1: When `amount` is 0, `data_out` equals `data_in` for every combination of `dir_left`, `op_rotate` and `op_arith`.
- R2: With `dir_left`=0, `op_rotate`=0 and `op_arith`=0, the word moves right by `amount` positions and zeros enter at the top. Amount 3 gives {0,0,0,bit3}.
- R3: With `dir_left`=0, `op_rotate`=0 and `op_arith`=1, the word moves right by `amount` and copies of bit 3 enter at the top. Amount 1 gives {bit3,bit3,bit2,bit1}.
- R4: With `dir_left`=1, `op_rotate`=0 and `op_arith`=0, the word moves left by `amount` and zeros enter at bit 0. Amount 2 gives {bit1,bit0,0,0}.
- R5: With `dir_left`=1, `op_rotate`=0 and `op_arith`=1, bit 3 of the output equals bit 3 of the input. Only bits 2..0 move left, and zeros enter at bit 0. Amount 1 gives {bit3,bit1,bit0,0} and amount 3 gives {bit3,0,0,0}.
- R6: With `dir_left`=0 and `op_rotate`=1, the word rotates right by `amount` (amount 1 gives {bit0,bit3,bit2,bit1}), and `op_arith` has no effect on the result.
- R7: With `dir_left`=1 and `op_rotate`=1, the word rotates left by `amount` (amount 1 gives {bit2,bit1,bit0,bit3}), and `op_arith` has no effect on the result.
- R8: With `OUT_REG`=1, `data_out` and `out_valid` take the result and the value of `in_valid` on the rising clock edge after the inputs are applied.
- R9: A high `rst` sampled on a rising edge sets `data_out` to 0 and `out_valid` to 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the inputs of this cycle as meaningful |
| data_in | input | 4 | Word to be moved |
| dir_left | input | 1 | 1 moves toward bit 3, 0 moves toward bit 0 |
| op_rotate | input | 1 | 1 rotates, 0 shifts |
| op_arith | input | 1 | 1 selects an arithmetic shift, 0 a logical one; ignored when rotating |
| amount | input | 2 | Number of positions, 0 to 3 |
| data_out | output | 4 | Result word |
| out_valid | output | 1 | Valid flag aligned with `data_out` |

## Verification
The bench applies every one of the 16 input words under every one of the 32 control codes. Each result is compared with a value computed from shifts and masks on integers.

The sweep covers several corner cases, each with a typical failure:
- Arithmetic left shift: a design that shifts all four bits there would lose the sign bit.
- Arithmetic right shift: a design that fills with zeros would differ on every word with bit 3 set.
- Rotate: the `op_arith` bit must change nothing, so a rotate that leaked it into the selection would give a shifted word.
- Select order: a tree wired with its select bits reversed would return the entry of a mirrored code.

A reset in the middle of the run and a pattern on `in_valid` that varies from vector to vector check the register and the flag.

// File: rtl/nsh_pkg.sv
package nsh_pkg;

    typedef enum logic [1:0] {
        KIND_LOGIC = 2'd0,
        KIND_ARITH = 2'd1,
        KIND_ROT   = 2'd2
    } shift_kind_e;

    function automatic shift_kind_e classify(input logic rot, input logic arith);
        if (rot)
            return KIND_ROT;
        else if (arith)
            return KIND_ARITH;
        else
            return KIND_LOGIC;
    endfunction

endpackage

// File: rtl/nsh_mux2.sv
module nsh_mux2 (
    input  logic a,
    input  logic b,
    input  logic s,
    output logic y
);
    assign y = s ? b : a;
endmodule

// File: rtl/nsh_column_build.sv
module nsh_column_build
    import nsh_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]                               data,
    output logic [WIDTH-1:0][(1 << (3 + $clog2(WIDTH)))-1:0] column
);
    localparam int AMT_W   = $clog2(WIDTH);
    localparam int CTRL_W  = 3 + AMT_W;
    localparam int ENTRIES = 1 << CTRL_W;

    always_comb begin
        for (int j = 0; j < WIDTH; j++) begin
            for (int c = 0; c < ENTRIES; c++) begin
                logic [CTRL_W-1:0] code;
                logic              left;
                shift_kind_e       kind;
                int                amt;
                int                src;
                code = CTRL_W'(c);
                left = code[CTRL_W-1];
                kind = classify(code[CTRL_W-2], code[CTRL_W-3]);
                amt  = int'(code[AMT_W-1:0]);
                src  = left ? (j - amt) : (j + amt);
                if (kind == KIND_ROT) begin
                    src = (src + WIDTH) % WIDTH;
                    column[j][c] = data[AMT_W'(src)];
                end else if (left && kind == KIND_ARITH && j == WIDTH - 1) begin
                    column[j][c] = data[WIDTH-1];
                end else if (src >= 0 && src < WIDTH) begin
                    column[j][c] = data[AMT_W'(src)];
                end else begin
                    column[j][c] = (!left && kind == KIND_ARITH) ? data[WIDTH-1] : 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/nsh_mux_tree.sv
module nsh_mux_tree #(
    parameter int SEL_W = 5
) (
    input  logic [(1 << SEL_W)-1:0] leaves,
    input  logic [SEL_W-1:0]        sel,
    output logic                    y
);
    localparam int N = 1 << SEL_W;

    for (genvar l = 0; l <= SEL_W; l++) begin : g_lvl
        localparam int CNT = N >> l;
        logic [CNT-1:0] node;
        if (l == 0) begin : g_leaf
            assign node = leaves;
        end else begin : g_red
            for (genvar k = 0; k < CNT; k++) begin : g_cell
                nsh_mux2 u_cell (
                    .a (g_lvl[l-1].node[k]),
                    .b (g_lvl[l-1].node[k+CNT]),
                    .s (sel[SEL_W-l]),
                    .y (node[k])
                );
            end
        end
    end

    assign y = g_lvl[SEL_W].node[0];
endmodule

// File: rtl/nibble_shifter.sv
module nibble_shifter #(
    parameter int WIDTH   = 4,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [WIDTH-1:0]         data_in,
    input  logic                     dir_left,
    input  logic                     op_rotate,
    input  logic                     op_arith,
    input  logic [$clog2(WIDTH)-1:0] amount,
    output logic [WIDTH-1:0]         data_out,
    output logic                     out_valid
);
    localparam int AMT_W   = $clog2(WIDTH);
    localparam int CTRL_W  = 3 + AMT_W;
    localparam int ENTRIES = 1 << CTRL_W;

    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             valid;
    } out_state_t;

    logic [WIDTH-1:0][ENTRIES-1:0] column;
    logic [CTRL_W-1:0]             code;
    logic [WIDTH-1:0]              result;
    out_state_t                    st_d, st_q;

    assign code = {dir_left, op_rotate, op_arith, amount};

    nsh_column_build #(.WIDTH(WIDTH)) u_cols (
        .data   (data_in),
        .column (column)
    );

    for (genvar j = 0; j < WIDTH; j++) begin : g_bit
        nsh_mux_tree #(.SEL_W(CTRL_W)) u_tree (
            .leaves (column[j]),
            .sel    (code),
            .y      (result[j])
        );
    end

    always_comb begin
        st_d.word  = result;
        st_d.valid = in_valid;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                st_q <= '0;
            else
                st_q <= st_d;
        end
    end else begin : g_comb
        assign st_q = st_d;
    end

    assign data_out  = st_q.word;
    assign out_valid = st_q.valid;
endmodule

// File: rtl/nibble_shifter_chk.sv
module nibble_shifter_chk #(
    parameter int WIDTH   = 4,
    parameter bit OUT_REG = 1'b1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [WIDTH-1:0]         data_in,
    input logic                     dir_left,
    input logic                     op_rotate,
    input logic                     op_arith,
    input logic [$clog2(WIDTH)-1:0] amount,
    input logic [WIDTH-1:0]         data_out,
    input logic                     out_valid
);
    if (OUT_REG) begin : g_chk
        assert_reset_clear_R9: assert property (@(posedge clk)
            rst |=> (data_out == '0 && !out_valid));

        assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);

        assert_valid_drop_R8: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);

        assert_zero_amount_R1: assert property (@(posedge clk) disable iff (rst)
            (amount == '0) |=> (data_out == $past(data_in)));

        assert_sign_held_left_R5: assert property (@(posedge clk) disable iff (rst)
            (dir_left && !op_rotate && op_arith) |=> (data_out[WIDTH-1] == $past(data_in[WIDTH-1])));

        assert_sign_held_right_R3: assert property (@(posedge clk) disable iff (rst)
            (!dir_left && !op_rotate && op_arith) |=> (data_out[WIDTH-1] == $past(data_in[WIDTH-1])));

        assert_rot_ones_R6_R7: assert property (@(posedge clk) disable iff (rst)
            op_rotate |=> ($countones(data_out) == $countones($past(data_in))));
    end
endmodule

bind nibble_shifter nibble_shifter_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .data_in   (data_in),
    .dir_left  (dir_left),
    .op_rotate (op_rotate),
    .op_arith  (op_arith),
    .amount    (amount),
    .data_out  (data_out),
    .out_valid (out_valid)
);

// File: tb/sim_nibble_shifter.sv
module sim_nibble_shifter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] data_in = '0;
    logic       dir_left = 1'b0;
    logic       op_rotate = 1'b0;
    logic       op_arith = 1'b0;
    logic [1:0] amount = '0;
    logic [3:0] data_out;
    logic       out_valid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nibble_shifter u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .data_in   (data_in),
        .dir_left  (dir_left),
        .op_rotate (op_rotate),
        .op_arith  (op_arith),
        .amount    (amount),
        .data_out  (data_out),
        .out_valid (out_valid)
    );

    function automatic int model(int d, int c);
        int left = (c >> 4) & 1;
        int rot  = (c >> 3) & 1;
        int ar   = (c >> 2) & 1;
        int a    = c & 3;
        int r;
        if (rot != 0) begin
            if (left != 0) r = (d << a) | (d >> (4 - a));
            else           r = (d >> a) | (d << (4 - a));
        end else if (left != 0) begin
            if (ar != 0) r = (d & 8) | ((d << a) & 7);
            else         r = d << a;
        end else begin
            if (ar != 0 && d >= 8) r = (d | ~15) >>> a;
            else                   r = d >> a;
        end
        return r & 15;
    endfunction

    function automatic string tag_of(int c);
        if ((c & 3) == 0) return "R1";
        if ((c & 8) != 0) return ((c & 16) != 0) ? "R7" : "R6";
        if ((c & 16) != 0) return ((c & 4) != 0) ? "R5" : "R4";
        return ((c & 4) != 0) ? "R3" : "R2";
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9", int'(data_out), 0);
        check("R9", int'(out_valid), 0);
        rst = 1'b0;
        for (int d = 0; d < 16; d++) begin
            for (int c = 0; c < 32; c++) begin
                int v;
                v = (d ^ c ^ (c >> 2)) & 1;
                data_in   = 4'(d);
                {dir_left, op_rotate, op_arith, amount} = 5'(c);
                in_valid  = v[0];
                @(posedge clk);
                @(negedge clk);
                check(tag_of(c), int'(data_out), model(d, c));
                check("R8", int'(out_valid), v);
            end
        end
        data_in = 4'hB;
        {dir_left, op_rotate, op_arith, amount} = 5'b00001;
        in_valid = 1'b1;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9", int'(data_out), 0);
        check("R9", int'(out_valid), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R2", int'(data_out), 5);
        check("R8", int'(out_valid), 1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule